// File: doc/BRIEF.md
# Bidirectional Handshake Strobe Repeater

This block relays a single handshake strobe between two bus segments, called side A and side B. It is clocked by the system clock and works in either direction. Two direction-enable inputs choose which way a strobe may travel. The strobe arriving on the enabled side is resynchronised and reshaped, and the block then drives it onto the other side through a data output and an output-enable. When the enable is low, the side is left undriven.

The forwarded pulse is conditioned in four ways:
- **Lock window.** After the leading edge, the output is frozen until both the hold window and the minimum pulse width have run out.
- **Tracking.** After the lock window, the output follows the input's level.
- **Data-clock delay.** A strobe flagged as a data clock has its leading edge held back by a fixed number of cycles. This gives the data on the far segment more setup time.
- **Quiet period.** After the output is released, the block ignores both inputs for a time. This stops it from picking up its own echo. In double-transition mode the quiet period is a trailing-edge filter followed by the blanking window. In single-transition mode it is the blanking window alone.

All windows are counted in clock cycles and set by parameters. A synchronous active-high reset clears everything.

Top module: `strobe_repeater`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `aOut`, `aOe`, `bOut` and `bOe` are all 0.
- R2: With `enAtoB` high and the path idle, an input `aIn` that is first high at clock edge k makes `bOe` and `bOut` rise at edge k+2 (for a strobe without the data-clock flag).
- R3: With `enBtoA` high, `enAtoB` low and the path idle, a rising `bIn` is forwarded to `aOe` and `aOut` with the same timing as R2.
- R4: A strobe arriving from a side whose direction enable is low produces no change on either output.
- R5: If both direction enables are high and both inputs rise at the same edge, only the A-to-B path is taken. The B input has no effect while that transfer and its quiet period last.
- R6: Once asserted, the output stays high for exactly LOCK = max(HOLD_CYC, MIN_WIDTH) cycles, or longer. Input glitches inside this window have no effect on the output.
- R7: After the lock window, the output follows the input. It falls at edge j+2 when the input is first low at edge j, giving an output no shorter than LOCK cycles.
- R8: When the source side's data-clock flag (`dclkA` or `dclkB`) is 1, the target output-enable still rises at k+2. The target output rises DCLK_DELAY cycles later.
- R9: The target's output-enable is high from the launch edge until the edge where its output falls. Both output-enables are never high together. An output is never high while its enable is low.
- R10: With `dtMode`=1 (double transition), both inputs are ignored for TRAIL_CYC+BLANK_CYC cycles after the output falls.
- R11: With `dtMode`=0 (single transition), both inputs are ignored for BLANK_CYC cycles after the output falls. An input seen after that window is forwarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| aIn | input | 1 | Strobe received from side A |
| bIn | input | 1 | Strobe received from side B |
| enAtoB | input | 1 | Allows forwarding from A to B |
| enBtoA | input | 1 | Allows forwarding from B to A |
| dclkA | input | 1 | Strobe from side A is a data clock |
| dclkB | input | 1 | Strobe from side B is a data clock |
| dtMode | input | 1 | 1 = double-transition mode, 0 = single-transition mode |
| aOut | output | 1 | Strobe driven onto side A |
| aOe | output | 1 | Output-enable for side A |
| bOut | output | 1 | Strobe driven onto side B |
| bOe | output | 1 | Output-enable for side B |

## Verification
Every output edge is due at a fixed cycle after the input change that causes it:
- **Launch and enable.** The output-enable and a plain strobe rise two edges after the first edge that sees the input high. This comes from two synchroniser flops and one sequencer flop.
- **Data-clock strobe.** The output rises DCLK_DELAY cycles after the enable.
- **Falling edge.** The output falls at the later of two edges: the end of the lock window, or two edges after the input is first seen low.

The bench works out the exact cycle of each edge from these rules and queues it. A monitor compares every output change against the head of the queue at the falling clock edge. A change that appears early or late, or that is missing, is reported against the requirement that predicted it. Stimuli that must be ignored are followed by a check that the queue was drained and no unexpected edge appeared.

// File: rtl/strb_rpt_pkg.sv
package strb_rpt_pkg;

  // Which window the shared counter is loaded with.
  typedef enum logic [1:0] {
    LD_DELAY = 2'd0,
    LD_LOCK  = 2'd1,
    LD_TRAIL = 2'd2,
    LD_BLANK = 2'd3
  } loadSel_e;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic     launch;     // claim the path and enable the target side
    logic     launchToB;  // direction chosen at launch
    logic     outOn;      // assert the target output
    logic     outOff;     // deassert output and release enable
    logic     cntLoad;    // load the window counter
    loadSel_e loadSel;    // window to load
  } ctrlStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DELAY  = 3'd1,
    ST_LOCK   = 3'd2,
    ST_FOLLOW = 3'd3,
    ST_TRAIL  = 3'd4,
    ST_BLANK  = 3'd5
  } pathState_e;

endpackage

// File: rtl/strb_rpt_dp.sv
module strb_rpt_dp
  import strb_rpt_pkg::*;
#(
  parameter int HOLD_CYC   = 4,
  parameter int MIN_WIDTH  = 6,
  parameter int DCLK_DELAY = 3,
  parameter int TRAIL_CYC  = 5,
  parameter int BLANK_CYC  = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         aIn,
  input  logic         bIn,
  input  ctrlStrobes_t ctrl,
  output logic         aSync,
  output logic         bSync,
  output logic         srcSync,
  output logic         cntZero,
  output logic         aOut,
  output logic         aOe,
  output logic         bOut,
  output logic         bOe
);

  localparam int LOCK_CYC = (HOLD_CYC > MIN_WIDTH) ? HOLD_CYC : MIN_WIDTH;
  localparam int MAX_AB   = (LOCK_CYC > DCLK_DELAY) ? LOCK_CYC : DCLK_DELAY;
  localparam int MAX_TB   = (TRAIL_CYC > BLANK_CYC) ? TRAIL_CYC : BLANK_CYC;
  localparam int MAX_WIN  = (MAX_AB > MAX_TB) ? MAX_AB : MAX_TB;
  localparam int CNT_W    = $clog2(MAX_WIN + 1);
  localparam int NUM_SIDE = 2;

  localparam logic [CNT_W-1:0] LOAD_DELAY =
    (DCLK_DELAY > 0) ? CNT_W'(DCLK_DELAY - 1) : '0;
  localparam logic [CNT_W-1:0] LOAD_LOCK  = CNT_W'(LOCK_CYC - 1);
  localparam logic [CNT_W-1:0] LOAD_TRAIL = CNT_W'(TRAIL_CYC - 1);
  localparam logic [CNT_W-1:0] LOAD_BLANK = CNT_W'(BLANK_CYC - 1);

  // Input synchronisers, one chain per side.
  logic [NUM_SIDE-1:0] rawIn;
  logic [NUM_SIDE-1:0] syncOut;
  assign rawIn = {bIn, aIn};

  for (genvar side = 0; side < NUM_SIDE; side++) begin : g_sync
    logic [SYNC_DEPTH-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[SYNC_DEPTH-2:0], rawIn[side]};
    end
    assign syncOut[side] = chain[SYNC_DEPTH-1];
  end

  assign aSync = syncOut[0];
  assign bSync = syncOut[1];

  // Window counter shared by every phase of a transfer.
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;

  always_comb begin
    unique case (ctrl.loadSel)
      LD_DELAY: loadVal = LOAD_DELAY;
      LD_LOCK:  loadVal = LOAD_LOCK;
      LD_TRAIL: loadVal = LOAD_TRAIL;
      default:  loadVal = LOAD_BLANK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (ctrl.cntLoad) cnt <= loadVal;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign cntZero = (cnt == '0);

  // Direction latch and output stage.
  logic dirToB;
  logic effToB;

  assign effToB = ctrl.launch ? ctrl.launchToB : dirToB;

  always_ff @(posedge clk) begin
    if (rst)              dirToB <= 1'b1;
    else if (ctrl.launch) dirToB <= ctrl.launchToB;
  end

  assign srcSync = dirToB ? aSync : bSync;

  always_ff @(posedge clk) begin
    if (rst) begin
      aOut <= 1'b0;
      aOe  <= 1'b0;
      bOut <= 1'b0;
      bOe  <= 1'b0;
    end else if (ctrl.outOff) begin
      aOut <= 1'b0;
      aOe  <= 1'b0;
      bOut <= 1'b0;
      bOe  <= 1'b0;
    end else begin
      if (ctrl.launch) begin
        if (ctrl.launchToB) bOe <= 1'b1;
        else                aOe <= 1'b1;
      end
      if (ctrl.outOn) begin
        if (effToB) bOut <= 1'b1;
        else        aOut <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/strb_rpt_ctrl.sv
module strb_rpt_ctrl
  import strb_rpt_pkg::*;
#(
  parameter int DCLK_DELAY = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         aSync,
  input  logic         bSync,
  input  logic         srcSync,
  input  logic         cntZero,
  input  logic         enAtoB,
  input  logic         enBtoA,
  input  logic         dclkA,
  input  logic         dclkB,
  input  logic         dtMode,
  output ctrlStrobes_t ctrl
);

  localparam logic DELAY_ON = (DCLK_DELAY > 0);

  pathState_e state, stateNext;
  logic endPulse;
  logic useDelay;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    ctrl      = '0;
    stateNext = state;
    endPulse  = 1'b0;
    useDelay  = 1'b0;

    unique case (state)
      ST_IDLE: begin
        // A-to-B wins when both directions see a strobe.
        if (enAtoB && aSync) begin
          ctrl.launch    = 1'b1;
          ctrl.launchToB = 1'b1;
          useDelay       = DELAY_ON && dclkA;
        end else if (enBtoA && bSync) begin
          ctrl.launch    = 1'b1;
          ctrl.launchToB = 1'b0;
          useDelay       = DELAY_ON && dclkB;
        end
        if (ctrl.launch) begin
          ctrl.cntLoad = 1'b1;
          if (useDelay) begin
            ctrl.loadSel = LD_DELAY;
            stateNext    = ST_DELAY;
          end else begin
            ctrl.outOn   = 1'b1;
            ctrl.loadSel = LD_LOCK;
            stateNext    = ST_LOCK;
          end
        end
      end

      ST_DELAY: begin
        if (cntZero) begin
          ctrl.outOn   = 1'b1;
          ctrl.cntLoad = 1'b1;
          ctrl.loadSel = LD_LOCK;
          stateNext    = ST_LOCK;
        end
      end

      ST_LOCK: begin
        if (cntZero) begin
          if (srcSync) stateNext = ST_FOLLOW;
          else         endPulse  = 1'b1;
        end
      end

      ST_FOLLOW: begin
        if (!srcSync) endPulse = 1'b1;
      end

      ST_TRAIL: begin
        if (cntZero) begin
          ctrl.cntLoad = 1'b1;
          ctrl.loadSel = LD_BLANK;
          stateNext    = ST_BLANK;
        end
      end

      ST_BLANK: begin
        if (cntZero) stateNext = ST_IDLE;
      end

      default: stateNext = ST_IDLE;
    endcase

    if (endPulse) begin
      ctrl.outOff  = 1'b1;
      ctrl.cntLoad = 1'b1;
      if (dtMode) begin
        ctrl.loadSel = LD_TRAIL;
        stateNext    = ST_TRAIL;
      end else begin
        ctrl.loadSel = LD_BLANK;
        stateNext    = ST_BLANK;
      end
    end
  end

endmodule

// File: rtl/strobe_repeater.sv
module strobe_repeater
  import strb_rpt_pkg::*;
#(
  parameter int HOLD_CYC   = 4,
  parameter int MIN_WIDTH  = 6,
  parameter int DCLK_DELAY = 3,
  parameter int TRAIL_CYC  = 5,
  parameter int BLANK_CYC  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic aIn,
  input  logic bIn,
  input  logic enAtoB,
  input  logic enBtoA,
  input  logic dclkA,
  input  logic dclkB,
  input  logic dtMode,
  output logic aOut,
  output logic aOe,
  output logic bOut,
  output logic bOe
);

  ctrlStrobes_t ctrl;
  logic aSync, bSync, srcSync, cntZero;

  strb_rpt_ctrl #(
    .DCLK_DELAY(DCLK_DELAY)
  ) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .aSync  (aSync),
    .bSync  (bSync),
    .srcSync(srcSync),
    .cntZero(cntZero),
    .enAtoB (enAtoB),
    .enBtoA (enBtoA),
    .dclkA  (dclkA),
    .dclkB  (dclkB),
    .dtMode (dtMode),
    .ctrl   (ctrl)
  );

  strb_rpt_dp #(
    .HOLD_CYC  (HOLD_CYC),
    .MIN_WIDTH (MIN_WIDTH),
    .DCLK_DELAY(DCLK_DELAY),
    .TRAIL_CYC (TRAIL_CYC),
    .BLANK_CYC (BLANK_CYC),
    .SYNC_DEPTH(2)
  ) dp_i (
    .clk    (clk),
    .rst    (rst),
    .aIn    (aIn),
    .bIn    (bIn),
    .ctrl   (ctrl),
    .aSync  (aSync),
    .bSync  (bSync),
    .srcSync(srcSync),
    .cntZero(cntZero),
    .aOut   (aOut),
    .aOe    (aOe),
    .bOut   (bOut),
    .bOe    (bOe)
  );

endmodule

// File: rtl/strobe_repeater_chk.sv
module strobe_repeater_chk #(
  parameter int HOLD_CYC  = 4,
  parameter int MIN_WIDTH = 6,
  parameter int BLANK_CYC = 4
) (
  input logic clk,
  input logic rst,
  input logic enAtoB,
  input logic enBtoA,
  input logic aOut,
  input logic aOe,
  input logic bOut,
  input logic bOe
);

  localparam int LOCK_CYC = (HOLD_CYC > MIN_WIDTH) ? HOLD_CYC : MIN_WIDTH;
  localparam logic [15:0] SAT = 16'hFFFF;

  logic [15:0] aHi, bHi, quiet;

  always_ff @(posedge clk) begin
    if (rst) begin
      aHi   <= '0;
      bHi   <= '0;
      quiet <= SAT;
    end else begin
      aHi   <= !aOut ? 16'd0 : (aHi == SAT ? SAT : aHi + 16'd1);
      bHi   <= !bOut ? 16'd0 : (bHi == SAT ? SAT : bHi + 16'd1);
      quiet <= (aOe || bOe) ? 16'd0 : (quiet == SAT ? SAT : quiet + 16'd1);
    end
  end

  assert_oe_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(aOe && bOe));

  assert_a_out_needs_oe_R9: assert property (@(posedge clk) disable iff (rst)
    aOut |-> aOe);

  assert_b_out_needs_oe_R9: assert property (@(posedge clk) disable iff (rst)
    bOut |-> bOe);

  assert_b_launch_enabled_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(bOe) |-> $past(enAtoB));

  assert_a_launch_enabled_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(aOe) |-> $past(enBtoA));

  assert_b_min_width_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(bOut) |-> (bHi >= 16'(LOCK_CYC)));

  assert_a_min_width_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(aOut) |-> (aHi >= 16'(LOCK_CYC)));

  assert_blank_gap_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(aOe || bOe) |-> (quiet >= 16'(BLANK_CYC)));

endmodule

bind strobe_repeater strobe_repeater_chk #(
  .HOLD_CYC (HOLD_CYC),
  .MIN_WIDTH(MIN_WIDTH),
  .BLANK_CYC(BLANK_CYC)
) chk_i (
  .clk   (clk),
  .rst   (rst),
  .enAtoB(enAtoB),
  .enBtoA(enBtoA),
  .aOut  (aOut),
  .aOe   (aOe),
  .bOut  (bOut),
  .bOe   (bOe)
);

// File: tb/strobe_repeater_tb_top.sv
module strobe_repeater_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD_CYC   = 4;
  localparam int MIN_WIDTH  = 6;
  localparam int DCLK_DELAY = 3;
  localparam int TRAIL_CYC  = 5;
  localparam int BLANK_CYC  = 4;
  localparam int LOCK       = (HOLD_CYC > MIN_WIDTH) ? HOLD_CYC : MIN_WIDTH;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic aIn = 1'b0, bIn = 1'b0;
  logic enAtoB = 1'b0, enBtoA = 1'b0;
  logic dclkA = 1'b0, dclkB = 1'b0;
  logic dtMode = 1'b0;
  logic aOut, aOe, bOut, bOe;

  always #(CLK_PERIOD / 2) clk = ~clk;

  strobe_repeater #(
    .HOLD_CYC  (HOLD_CYC),
    .MIN_WIDTH (MIN_WIDTH),
    .DCLK_DELAY(DCLK_DELAY),
    .TRAIL_CYC (TRAIL_CYC),
    .BLANK_CYC (BLANK_CYC)
  ) dut_i (
    .clk(clk), .rst(rst), .aIn(aIn), .bIn(bIn),
    .enAtoB(enAtoB), .enBtoA(enBtoA), .dclkA(dclkA), .dclkB(dclkB),
    .dtMode(dtMode), .aOut(aOut), .aOe(aOe), .bOut(bOut), .bOe(bOe)
  );

  // Signal index: 0 aOut, 1 aOe, 2 bOut, 3 bOe
  typedef struct {
    int    cyc;
    int    sig;
    bit    val;
    string req;
  } expEvt_t;

  expEvt_t expQ[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit monOn = 1'b0;
  bit done = 1'b0;
  string curReq = "R1";
  logic [3:0] prevOut;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [3:0] outVec();
    return {bOe, bOut, aOe, aOut};
  endfunction

  // Monitor: compares each output change with the head of the queue.
  always @(negedge clk) begin
    if (monOn && !done) begin
      logic [3:0] cur;
      cur = outVec();
      for (int s = 0; s < 4; s++) begin
        if (cur[s] !== prevOut[s]) begin
          checks++;
          if (expQ.size() == 0) begin
            errors++;
            $display("FAIL %s: unexpected change sig%0d actual %0b at cycle %0d expected no change",
                     curReq, s, cur[s], cyc);
          end else begin
            expEvt_t e;
            e = expQ.pop_front();
            if (e.cyc != cyc || e.sig != s || e.val != cur[s]) begin
              errors++;
              $display("FAIL %s: actual sig%0d=%0b at cycle %0d expected sig%0d=%0b at cycle %0d",
                       e.req, s, cur[s], cyc, e.sig, e.val, e.cyc);
            end
          end
        end
      end
      prevOut = cur;
    end
  end

  task automatic push(int c, int s, bit v, string r);
    expEvt_t e;
    e.cyc = c; e.sig = s; e.val = v; e.req = r;
    expQ.push_back(e);
  endtask

  task automatic waitUntil(int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Forward one pulse from a side; called at a negedge with the path idle.
  task automatic forward(bit fromA, int width, bit dclk, string rRise,
                         string rFall, output int offCyc);
    int n, launch, rise, off, outSig, oeSig;
    n      = cyc;
    launch = n + 3;
    rise   = launch + (dclk ? DCLK_DELAY : 0);
    off    = (n + width + 3 > rise + LOCK) ? n + width + 3 : rise + LOCK;
    outSig = fromA ? 2 : 0;
    oeSig  = outSig + 1;
    if (dclk) begin
      push(launch, oeSig, 1'b1, rRise);
      push(rise, outSig, 1'b1, rRise);
    end else begin
      push(rise, outSig, 1'b1, rRise);
      push(launch, oeSig, 1'b1, "R9");
    end
    push(off, outSig, 1'b0, rFall);
    push(off, oeSig, 1'b0, "R9");
    if (fromA) aIn = 1'b1; else bIn = 1'b1;
    repeat (width) @(negedge clk);
    if (fromA) aIn = 1'b0; else bIn = 1'b0;
    offCyc = off;
  endtask

  task automatic checkQuiet(string r);
    checks++;
    if (expQ.size() != 0 || outVec() != 4'b0000) begin
      errors++;
      $display("FAIL %s: actual pending=%0d outs=%b expected pending=0 outs=0000",
               r, expQ.size(), outVec());
    end
  endtask

  task automatic shortPulse(bit fromA);
    if (fromA) aIn = 1'b1; else bIn = 1'b1;
    @(negedge clk);
    if (fromA) aIn = 1'b0; else bIn = 1'b0;
  endtask

  initial begin
    int off, n;
    repeat (3) @(negedge clk);
    // R1: reset state
    curReq = "R1";
    checks++;
    if (outVec() !== 4'b0000) begin
      errors++;
      $display("FAIL R1: actual outs=%b expected 0000 in reset", outVec());
    end
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (outVec() !== 4'b0000) begin
      errors++;
      $display("FAIL R1: actual outs=%b expected 0000 after reset", outVec());
    end
    prevOut = outVec();
    monOn = 1'b1;

    // R2/R7: long plain pulse A to B, output follows input
    curReq = "R2"; enAtoB = 1'b1; dtMode = 1'b0;
    forward(1'b1, 10, 1'b0, "R2", "R7", off);
    waitUntil(off + BLANK_CYC + 3);

    // R6: short pulse stretched to the lock window
    curReq = "R6";
    forward(1'b1, 2, 1'b0, "R2", "R6", off);
    waitUntil(off + BLANK_CYC + 3);

    // R6: glitches inside the lock window are ignored
    n = cyc;
    push(n + 3, 2, 1'b1, "R2");
    push(n + 3, 3, 1'b1, "R9");
    push(n + 3 + LOCK, 2, 1'b0, "R6");
    push(n + 3 + LOCK, 3, 1'b0, "R9");
    aIn = 1'b1; @(negedge clk);
    aIn = 1'b0; @(negedge clk);
    aIn = 1'b1; @(negedge clk);
    aIn = 1'b0;
    waitUntil(n + 3 + LOCK + BLANK_CYC + 3);

    // R8: data-clock strobe delayed, enable at launch
    curReq = "R8"; dclkA = 1'b1;
    forward(1'b1, 10, 1'b1, "R8", "R7", off);
    dclkA = 1'b0;
    waitUntil(off + BLANK_CYC + 3);

    // R3: B to A path, also with data-clock flag
    curReq = "R3"; enAtoB = 1'b0; enBtoA = 1'b1;
    forward(1'b0, 8, 1'b0, "R3", "R7", off);
    waitUntil(off + BLANK_CYC + 3);
    dclkB = 1'b1;
    forward(1'b0, 3, 1'b1, "R8", "R6", off);
    dclkB = 1'b0;
    waitUntil(off + BLANK_CYC + 3);

    // R4: disabled direction ignored
    curReq = "R4";
    aIn = 1'b1;
    repeat (12) @(negedge clk);
    aIn = 1'b0;
    repeat (6) @(negedge clk);
    checkQuiet("R4");

    // R5: both directions enabled, A wins
    curReq = "R5"; enAtoB = 1'b1;
    bIn = 1'b1;
    n = cyc;
    push(n + 3, 2, 1'b1, "R5");
    push(n + 3, 3, 1'b1, "R5");
    push(n + 11, 2, 1'b0, "R5");
    push(n + 11, 3, 1'b0, "R5");
    aIn = 1'b1;
    repeat (2) @(negedge clk);
    bIn = 1'b0;
    repeat (6) @(negedge clk);
    aIn = 1'b0;
    waitUntil(n + 11 + BLANK_CYC + 4);
    checkQuiet("R5");
    enBtoA = 1'b0;

    // R10: double-transition mode ignores input for trail plus blank
    curReq = "R10"; dtMode = 1'b1;
    forward(1'b1, 3, 1'b0, "R2", "R6", off);
    waitUntil(off + BLANK_CYC + 1);
    shortPulse(1'b1);
    waitUntil(off + TRAIL_CYC + BLANK_CYC + 8);
    checkQuiet("R10");

    // R11: single-transition mode, blank only
    curReq = "R11"; dtMode = 1'b0;
    forward(1'b1, 3, 1'b0, "R2", "R6", off);
    waitUntil(off);
    shortPulse(1'b1);   // inside blanking: ignored
    waitUntil(off + BLANK_CYC + 1);
    forward(1'b1, 1, 1'b0, "R11", "R6", off);
    waitUntil(off + BLANK_CYC + 4);
    checkQuiet("R11");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL %s: actual watchdog expired expected completion", curReq);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule